// File: doc/BRIEF.md
# Serial NOR Flash Operation Sequencer

This block accepts one high-level flash operation at a time and breaks it into the ordered chain of single-command transactions that a serial NOR flash requires. It sits above a transaction engine that owns the serial line timing. The sequencer presents one transaction at a time: an opcode, an optional address, a byte count and an optional write byte. It holds the request until the engine accepts it, then waits for the engine to report completion along with any byte read back.

Four operations are supported. Entering quad mode writes the volatile configuration byte with its quad-disable bit cleared. A sector erase and a page program each put a write-enable in front of the command, then poll the status byte until the write-in-progress flag drops. The poll loop is bounded by a programmable limit, and when that limit is exhausted the operation ends with a timeout error. A quad read is issued directly. A program request whose byte range would run past the end of a page is refused before any traffic starts.

Top module: `flash_op_seq`

## Requirements
- R1: After a synchronous active-low reset, busy, done, err_timeout, err_cross and txn_valid are all 0.
- R2: op_kind 1 (erase) issues opcode 0x06, then opcode 0x20 with txn_use_addr=1 and the request address, then status reads (opcode 0x05, txn_len=1).
- R3: op_kind 2 (program) issues opcode 0x06, then opcode 0x02 with txn_use_addr=1, the request address and txn_len equal to op_len, then status reads.
- R4: op_kind 0 (quad enable) issues opcode 0x06, then opcode 0x61 with txn_len=1 and txn_wbyte equal to CFG_IMAGE with bit 7 cleared (0x7F by default). No status read follows, and the operation ends with done.
- R5: op_kind 3 (read) issues a single opcode 0xEB transaction with txn_use_addr=1, the request address and length, with no write-enable in front of it, and then ends with done.
- R6: Polling stops at the first status byte whose bit 0 is 0, whatever its other bits hold. done then pulses for exactly one cycle.
- R7: If poll_limit status reads in a row all return bit 0 = 1, no further read is issued and err_timeout pulses for one cycle. A poll_limit of 0 acts as 1.
- R8: A program request with op_len = 0, or with (op_addr mod 256) + op_len > 256, is refused. err_cross pulses in the cycle after the request, busy stays 0 and no transaction is issued.
- R9: busy rises in the cycle after an accepted request and falls in the same cycle in which done or err_timeout pulses.
- R10: op_valid is ignored while busy is 1. The transaction sequence and the outcome of the running operation are unchanged.
- R11: Once txn_valid is raised, it stays high with its opcode and address unchanged until the cycle in which txn_ready is sampled high.
- R12: Every 0x20, 0x02 or 0x61 transaction is issued only after a 0x06 transaction has been the most recently completed one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation request strobe |
| op_kind | input | 2 | 0 quad enable, 1 erase, 2 program, 3 read |
| op_addr | input | ADDR_W | Flash byte address of the operation |
| op_len | input | LEN_W | Byte count for program or read (1 to 256) |
| poll_limit | input | TO_W | Maximum number of status reads per wait |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: operation completed |
| err_timeout | output | 1 | One-cycle pulse: status poll limit exhausted |
| err_cross | output | 1 | One-cycle pulse: program request refused |
| txn_valid | output | 1 | Transaction request to the engine |
| txn_ready | input | 1 | Engine accepts the transaction |
| txn_opcode | output | 8 | Command byte of the transaction |
| txn_use_addr | output | 1 | Transaction carries an address phase |
| txn_addr | output | ADDR_W | Address of the transaction |
| txn_len | output | LEN_W | Data bytes to move in the transaction |
| txn_wbyte | output | 8 | Single data byte for a register write |
| txn_done | input | 1 | Engine finished the accepted transaction |
| txn_rdata | input | 8 | Byte read back (status value) with txn_done |

## Verification
The assertions assume that the engine raises txn_done only after accepting a transaction and never while a request is still waiting for txn_ready. They also assume that poll_limit stays constant while busy is high. The bench keeps to both. Its engine model answers each request after a fixed delay and only once per acceptance, and poll_limit is changed only between operations while the block is idle. The status bytes it returns always set bit 1, so only bit 0 can end a poll.

// File: rtl/flash_seq_pkg.sv
// Shared types and command constants for the flash operation sequencer.
// Assumes a flash whose status register holds write-in-progress in bit 0
// and whose volatile configuration byte disables quad I/O when bit 7 is 1.
package flash_seq_pkg;

    typedef enum logic [1:0] {
        OPK_QUAD  = 2'd0,
        OPK_ERASE = 2'd1,
        OPK_PROG  = 2'd2,
        OPK_READ  = 2'd3
    } op_kind_t;

    typedef enum logic [1:0] {
        STEP_WREN = 2'd0,
        STEP_MAIN = 2'd1,
        STEP_POLL = 2'd2
    } step_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_REQ  = 2'd1,
        PH_WAIT = 2'd2
    } phase_t;

    localparam logic [7:0] OPC_WREN    = 8'h06;
    localparam logic [7:0] OPC_RDSR    = 8'h05;
    localparam logic [7:0] OPC_WRVCFG  = 8'h61;
    localparam logic [7:0] OPC_SSERASE = 8'h20;
    localparam logic [7:0] OPC_PROG    = 8'h02;
    localparam logic [7:0] OPC_QREAD   = 8'hEB;

    localparam int WIP_BIT  = 0;
    localparam int QUAD_BIT = 7;

endpackage

// File: rtl/flash_page_check.sv
// Decides whether a program request stays inside one page.
// Assumes PAGE_BYTES is a power of two and len counts bytes from 1 to PAGE_BYTES.
module flash_page_check #(
    parameter int ADDR_W     = 24,
    parameter int PAGE_BYTES = 256,
    parameter int LEN_W      = $clog2(PAGE_BYTES) + 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output logic              fits
);
    localparam int PAGE_W = $clog2(PAGE_BYTES);

    logic [LEN_W:0] end_pos;

    // Offset inside the page plus length must not pass the page end.
    always_comb begin
        end_pos = {2'b00, addr[PAGE_W-1:0]} + {1'b0, len};
        fits    = (len != '0) && (end_pos <= (LEN_W+1)'(PAGE_BYTES));
    end
endmodule

// File: rtl/flash_poll_timer.sv
// Counts completed status reads during one busy wait and flags the last allowed one.
// Assumes limit is stable while active; a limit of zero is treated as one read.
module flash_poll_timer #(
    parameter int TO_W = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            bump,
    input  logic            active,
    input  logic [TO_W-1:0] limit,
    output logic            last
);
    logic [TO_W-1:0] count_q;
    logic [TO_W:0]   eff_limit;
    logic [TO_W:0]   next_count;

    // Effective limit and whether the read now in flight is the final one.
    always_comb begin
        eff_limit  = (limit == '0) ? (TO_W+1)'(1) : {1'b0, limit};
        next_count = {1'b0, count_q} + (TO_W+1)'(1);
        last       = (next_count >= eff_limit);
    end

    // Poll counter: cleared at operation accept, advanced after each busy status.
    always_ff @(posedge clk) begin
        if (!rst_n)      count_q <= '0;
        else if (clear)  count_q <= '0;
        else if (bump)   count_q <= count_q + 1'b1;
    end

    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> ({1'b0, count_q} < eff_limit));
endmodule

// File: rtl/flash_op_seq.sv
// Flash operation sequencer: turns quad-enable, erase, program and read requests
// into ordered single-command transactions, with write-enable in front of every
// modifying command and a bounded status poll after erase and program.
// Assumes the engine answers each accepted transaction with exactly one txn_done.
module flash_op_seq
    import flash_seq_pkg::*;
#(
    parameter int         ADDR_W     = 24,
    parameter int         PAGE_BYTES = 256,
    parameter int         TO_W       = 20,
    parameter logic [7:0] CFG_IMAGE  = 8'hFF,
    parameter int         LEN_W      = $clog2(PAGE_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [LEN_W-1:0]  op_len,
    input  logic [TO_W-1:0]   poll_limit,
    output logic              busy,
    output logic              done,
    output logic              err_timeout,
    output logic              err_cross,
    output logic              txn_valid,
    input  logic              txn_ready,
    output logic [7:0]        txn_opcode,
    output logic              txn_use_addr,
    output logic [ADDR_W-1:0] txn_addr,
    output logic [LEN_W-1:0]  txn_len,
    output logic [7:0]        txn_wbyte,
    input  logic              txn_done,
    input  logic [7:0]        txn_rdata
);
    localparam int         PAGE_W   = $clog2(PAGE_BYTES);
    localparam logic [7:0] QUAD_CFG = CFG_IMAGE & ~(8'h01 << QUAD_BIT);

    op_kind_t          req_kind;
    op_kind_t          kind_q;
    phase_t            phase_q;
    step_t             step_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic              busy_q, done_q, to_q, cross_q;
    logic [7:0]        last_opc_q;
    logic              page_fits;
    logic              take_req, refuse_req;
    logic              poll_last, poll_clear, poll_bump;
    logic              txn_end, still_busy;

    assign req_kind = op_kind_t'(op_kind);

    flash_page_check #(
        .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .LEN_W(LEN_W)
    ) u_page (
        .addr(op_addr), .len(op_len), .fits(page_fits)
    );

    flash_poll_timer #(.TO_W(TO_W)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .clear(poll_clear), .bump(poll_bump),
        .active(busy_q && step_q == STEP_POLL),
        .limit(poll_limit), .last(poll_last)
    );

    // Request screening: accept when idle, refuse program requests that leave the page.
    always_comb begin
        refuse_req = (phase_q == PH_IDLE) && op_valid &&
                     (req_kind == OPK_PROG) && !page_fits;
        take_req   = (phase_q == PH_IDLE) && op_valid && !refuse_req;
        txn_end    = (phase_q == PH_WAIT) && txn_done;
        still_busy = txn_rdata[WIP_BIT];
        poll_clear = take_req;
        poll_bump  = txn_end && (step_q == STEP_POLL) && still_busy && !poll_last;
    end

    // Transaction field decode from the current step and operation kind.
    always_comb begin
        txn_opcode   = OPC_WREN;
        txn_use_addr = 1'b0;
        txn_addr     = '0;
        txn_len      = '0;
        txn_wbyte    = 8'h00;
        unique case (step_q)
            STEP_WREN: txn_opcode = OPC_WREN;
            STEP_POLL: begin
                txn_opcode = OPC_RDSR;
                txn_len    = LEN_W'(1);
            end
            default: begin
                unique case (kind_q)
                    OPK_QUAD: begin
                        txn_opcode = OPC_WRVCFG;
                        txn_len    = LEN_W'(1);
                        txn_wbyte  = QUAD_CFG;
                    end
                    OPK_ERASE: begin
                        txn_opcode   = OPC_SSERASE;
                        txn_use_addr = 1'b1;
                        txn_addr     = addr_q;
                    end
                    OPK_PROG: begin
                        txn_opcode   = OPC_PROG;
                        txn_use_addr = 1'b1;
                        txn_addr     = addr_q;
                        txn_len      = len_q;
                    end
                    default: begin
                        txn_opcode   = OPC_QREAD;
                        txn_use_addr = 1'b1;
                        txn_addr     = addr_q;
                        txn_len      = len_q;
                    end
                endcase
            end
        endcase
    end

    // Main sequencer: phase walks request/wait, step walks write-enable/command/poll.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            step_q  <= STEP_WREN;
            kind_q  <= OPK_QUAD;
            addr_q  <= '0;
            len_q   <= '0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            to_q    <= 1'b0;
            cross_q <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            to_q    <= 1'b0;
            cross_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (refuse_req) begin
                        cross_q <= 1'b1;
                    end else if (take_req) begin
                        kind_q  <= req_kind;
                        addr_q  <= op_addr;
                        len_q   <= op_len;
                        busy_q  <= 1'b1;
                        phase_q <= PH_REQ;
                        step_q  <= (req_kind == OPK_READ) ? STEP_MAIN : STEP_WREN;
                    end
                end
                PH_REQ: begin
                    if (txn_ready) phase_q <= PH_WAIT;
                end
                default: begin
                    if (txn_done) begin
                        unique case (step_q)
                            STEP_WREN: begin
                                step_q  <= STEP_MAIN;
                                phase_q <= PH_REQ;
                            end
                            STEP_MAIN: begin
                                if (kind_q == OPK_ERASE || kind_q == OPK_PROG) begin
                                    step_q  <= STEP_POLL;
                                    phase_q <= PH_REQ;
                                end else begin
                                    phase_q <= PH_IDLE;
                                    busy_q  <= 1'b0;
                                    done_q  <= 1'b1;
                                end
                            end
                            default: begin
                                if (!still_busy) begin
                                    phase_q <= PH_IDLE;
                                    busy_q  <= 1'b0;
                                    done_q  <= 1'b1;
                                end else if (poll_last) begin
                                    phase_q <= PH_IDLE;
                                    busy_q  <= 1'b0;
                                    to_q    <= 1'b1;
                                end else begin
                                    phase_q <= PH_REQ;
                                end
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    // Remember the opcode of the most recently completed transaction.
    always_ff @(posedge clk) begin
        if (!rst_n)       last_opc_q <= 8'h00;
        else if (txn_end) last_opc_q <= txn_opcode;
    end

    assign busy        = busy_q;
    assign done        = done_q;
    assign err_timeout = to_q;
    assign err_cross   = cross_q;
    assign txn_valid   = (phase_q == PH_REQ);

    // R9
    busy_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> busy);

    // R9
    done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err_timeout) |-> (!busy && $past(busy)));

    // R11
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ready) |=>
            (txn_valid && $stable(txn_opcode) && $stable(txn_addr)));

    // R12
    wren_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && (txn_opcode == OPC_SSERASE || txn_opcode == OPC_PROG ||
                       txn_opcode == OPC_WRVCFG)) |-> (last_opc_q == OPC_WREN));

    // R6
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err_timeout, err_cross}));

    // R8
    refuse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_cross |-> (!busy && !txn_valid));

    // R8
    page_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_opcode == OPC_PROG) |->
            (txn_len != '0 &&
             ({1'b0, txn_addr[PAGE_W-1:0]} + {1'b0, txn_len}) <= (LEN_W+1)'(PAGE_BYTES)));
endmodule

// File: tb/flash_op_seq_tb.sv
// Bench: behavioural engine/flash model plus a per-clock reference of the outcome ports.
module flash_op_seq_tb;
    localparam int ADDR_W = 24;
    localparam int LEN_W  = 9;
    localparam int TO_W   = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              op_valid = 1'b0;
    logic [1:0]        op_kind = 2'd0;
    logic [ADDR_W-1:0] op_addr = '0;
    logic [LEN_W-1:0]  op_len = '0;
    logic [TO_W-1:0]   poll_limit = '0;
    logic              busy, done, err_timeout, err_cross, txn_valid;
    logic              txn_ready = 1'b0;
    logic [7:0]        txn_opcode, txn_wbyte;
    logic              txn_use_addr;
    logic [ADDR_W-1:0] txn_addr;
    logic [LEN_W-1:0]  txn_len;
    logic              txn_done = 1'b0;
    logic [7:0]        txn_rdata = 8'h00;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    flash_op_seq u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_addr(op_addr), .op_len(op_len), .poll_limit(poll_limit),
        .busy(busy), .done(done), .err_timeout(err_timeout), .err_cross(err_cross),
        .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_opcode(txn_opcode),
        .txn_use_addr(txn_use_addr), .txn_addr(txn_addr), .txn_len(txn_len),
        .txn_wbyte(txn_wbyte), .txn_done(txn_done), .txn_rdata(txn_rdata)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Engine/flash model: holds each request one cycle, then answers after a delay.
    int         busy_left = 0;
    bit         in_txn = 0;
    int         dly = 0;
    int         hold = 1;
    logic [7:0] held_op = 8'h00;
    logic [7:0] cap_op = 8'h00, cap_wbyte = 8'h00;
    logic [ADDR_W-1:0] cap_addr = '0;
    logic [LEN_W-1:0]  cap_len = '0;
    logic       cap_use = 1'b0;

    always @(negedge clk) begin
        txn_ready = 1'b0;
        txn_done  = 1'b0;
        if (!rst_n) begin
            in_txn = 0;
            hold   = 1;
        end else if (in_txn) begin
            if (dly == 0) begin
                txn_done = 1'b1;
                if (cap_op == 8'h05) begin
                    txn_rdata = (busy_left > 0) ? 8'h03 : 8'h02;
                    if (busy_left > 0) busy_left--;
                end else begin
                    txn_rdata = 8'h00;
                end
                in_txn = 0;
            end else begin
                dly--;
            end
        end else if (txn_valid) begin
            if (hold > 0) begin
                held_op = txn_opcode;
                hold--;
            end else begin
                // R11: request held unchanged while not accepted
                check(txn_opcode == held_op, "R11", "held opcode", txn_opcode, held_op);
                txn_ready = 1'b1;
                cap_op    = txn_opcode;
                cap_addr  = txn_addr;
                cap_len   = txn_len;
                cap_use   = txn_use_addr;
                cap_wbyte = txn_wbyte;
                in_txn    = 1;
                dly       = 2;
                hold      = 1;
            end
        end
    end

    // Reference model, stepped just after each rising edge.
    logic [7:0] exp_op[$];
    string      exp_tag[$];
    bit         m_busy = 0, m_done = 0, m_to = 0, m_cross = 0, m_out_to = 0;
    logic [ADDR_W-1:0] m_addr = '0;
    logic [LEN_W-1:0]  m_len = '0;

    always @(posedge clk) begin
        #1;
        m_done = 0; m_to = 0; m_cross = 0;
        if (!rst_n) begin
            m_busy = 0;
            exp_op.delete();
            exp_tag.delete();
        end else if (m_busy) begin
            if (txn_ready) begin
                if (exp_op.size() == 0) begin
                    check(0, "R10", "unexpected transaction", cap_op, 0);
                end else begin
                    check(cap_op == exp_op[0], exp_tag[0], "opcode", cap_op, exp_op[0]);
                    if (cap_op == 8'h20 || cap_op == 8'h02 || cap_op == 8'hEB) begin
                        check(cap_use && cap_addr == m_addr, exp_tag[0], "address",
                              cap_addr, m_addr);
                        if (cap_op != 8'h20)
                            check(cap_len == m_len, exp_tag[0], "length", cap_len, m_len);
                    end
                    if (cap_op == 8'h61)
                        check(cap_wbyte == 8'h7F && cap_len == 1, "R4", "config byte",
                              cap_wbyte, 8'h7F);
                    if (cap_op == 8'h05)
                        check(cap_len == 1, "R2", "status length", cap_len, 1);
                    void'(exp_op.pop_front());
                    void'(exp_tag.pop_front());
                end
            end
            if (txn_done && exp_op.size() == 0) begin
                m_busy = 0;
                if (m_out_to) m_to = 1; else m_done = 1;
            end
        end else if (op_valid) begin
            int eff, n;
            if (op_kind == 2'd2 && (op_len == 0 || int'(op_addr[7:0]) + int'(op_len) > 256)) begin
                m_cross = 1;
            end else begin
                m_busy   = 1;
                m_addr   = op_addr;
                m_len    = op_len;
                m_out_to = 0;
                if (op_kind != 2'd3) begin
                    exp_op.push_back(8'h06); exp_tag.push_back("R12");
                end
                case (op_kind)
                    2'd0: begin exp_op.push_back(8'h61); exp_tag.push_back("R4"); end
                    2'd1: begin exp_op.push_back(8'h20); exp_tag.push_back("R2"); end
                    2'd2: begin exp_op.push_back(8'h02); exp_tag.push_back("R3"); end
                    default: begin exp_op.push_back(8'hEB); exp_tag.push_back("R5"); end
                endcase
                if (op_kind == 2'd1 || op_kind == 2'd2) begin
                    eff = (poll_limit == 0) ? 1 : int'(poll_limit);
                    if (busy_left + 1 <= eff) n = busy_left + 1;
                    else begin n = eff; m_out_to = 1; end
                    for (int i = 0; i < n; i++) begin
                        exp_op.push_back(8'h05);
                        exp_tag.push_back(m_out_to ? "R7" : "R6");
                    end
                end
            end
        end
        if (rst_n) begin
            check(busy == m_busy, "R9", "busy", busy, m_busy);
            check(done == m_done, "R6", "done", done, m_done);
            check(err_timeout == m_to, "R7", "err_timeout", err_timeout, m_to);
            check(err_cross == m_cross, "R8", "err_cross", err_cross, m_cross);
        end
    end

    // Issue one operation and wait for it to finish; optionally poke op_valid mid-run.
    task automatic run_op(input int kind, input int addr, input int len,
                          input int limit, input int polls, input bit poke);
        @(negedge clk);
        busy_left  = polls;
        poll_limit = TO_W'(limit);
        op_kind    = 2'(kind);
        op_addr    = ADDR_W'(addr);
        op_len     = LEN_W'(len);
        op_valid   = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        if (poke) begin
            repeat (5) @(negedge clk);
            // R10: request while busy must be ignored
            op_kind  = 2'd3;
            op_addr  = 24'h55AA55;
            op_valid = 1'b1;
            @(negedge clk);
            op_valid = 1'b0;
        end
        for (int w = 0; w < 5000 && m_busy; w++) @(negedge clk);
        repeat (3) @(negedge clk);
        check(exp_op.size() == 0, "R10", "pending transactions", exp_op.size(), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(busy == 0 && done == 0, "R1", "busy/done in reset", {busy, done}, 0);
        check(err_timeout == 0 && err_cross == 0, "R1", "errors in reset",
              {err_timeout, err_cross}, 0);
        check(txn_valid == 0, "R1", "txn_valid in reset", txn_valid, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(busy == 0 && txn_valid == 0, "R1", "idle after reset", {busy, txn_valid}, 0);

        run_op(0, 0, 0, 4, 0, 0);            // R4 quad enable
        run_op(1, 'h012345, 0, 10, 3, 0);    // R2 erase, three busy polls
        run_op(2, 'h000100, 256, 5, 0, 0);   // R3 full page
        run_op(2, 'h0000FF, 1, 5, 1, 0);     // R3 last byte of page
        run_op(2, 'h0000FF, 2, 5, 0, 0);     // R8 crosses page
        run_op(2, 'h000010, 0, 5, 0, 0);     // R8 zero length
        run_op(3, 'hABCDEF, 16, 5, 0, 0);    // R5 read
        run_op(1, 'h002000, 0, 3, 5, 0);     // R7 timeout after three polls
        run_op(1, 'h003000, 0, 0, 4, 0);     // R7 limit zero acts as one
        run_op(1, 'h004000, 0, 3, 2, 0);     // R6 done on the last allowed poll
        run_op(2, 'h000200, 8, 6, 3, 1);     // R10 request while busy

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog R9 actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule